// File: doc/BRIEF.md
# DLL Periodic Re-lock Timer

While a memory controller sits in its deepest low-power state, with both the memory clock and its own clock gated, only a small part of its DLL keeps running. Supply voltage and die temperature keep drifting, and a DLL left gated for a long time can fall out of range of the controller clock. This block wakes the DLL on a fixed schedule. It gates the DLL clock for a programmable number of cycles. It then un-gates the clock for a re-lock window that lasts at least a fixed minimum number of cycles and ends only once the DLL reports lock. After that it gates the clock again and starts a new countdown.

The controller's power-mode logic drives `deep_gated` high while the deepest mode is active. Whenever that flag is low, the DLL clock stays enabled and the timer does nothing. The hold interval is sampled each time a countdown is loaded, so software can change it between windows. A hold value of zero is handled as one cycle.

Top module: `dllr_relock_timer`

## Requirements
- R1: During reset and in the first cycle after reset, `dll_clk_en` is 1 and `relock_busy` is 0.
- R2: While `deep_gated` is 0, `dll_clk_en` stays 1 and `relock_busy` stays 0, and changes on `hold_interval` or `dll_lock` have no visible effect.
- R3: When `deep_gated` is sampled high in the open state, the countdown loads `hold_interval` at that edge. `dll_clk_en` is then 0 for exactly that many cycles, starting with the next cycle.
- R4: A `hold_interval` of 0 is treated as 1: the gated phase lasts exactly one cycle.
- R5: When the countdown expires, the next cycle shows `dll_clk_en` = 1 and `relock_busy` = 1 (the re-lock window begins).
- R6: A re-lock window lasts at least MIN_WIN cycles (16 by default), even if `dll_lock` is high for the whole window.
- R7: If `dll_lock` is first sampled high in window cycle d, where d > MIN_WIN, the window lasts exactly d cycles. In the cycle after that, `dll_clk_en` is 0.
- R8: At the edge that ends a window, the countdown reloads from the `hold_interval` value present at that edge. The gate, re-lock, gate pattern then repeats for as long as `deep_gated` stays high.
- R9: If `deep_gated` is sampled low in any state, the next cycle shows `dll_clk_en` = 1 and `relock_busy` = 0. A later re-entry starts a full new countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the timer logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| deep_gated | input | 1 | High while the deepest low-power mode (memory and controller clocks gated) is active |
| hold_interval | input | HOLD_W | Number of gated cycles between re-lock windows; 0 counts as 1 |
| dll_lock | input | 1 | Lock indication from the DLL |
| dll_clk_en | output | 1 | 1 = DLL clock running, 0 = DLL clock gated |
| relock_busy | output | 1 | High during a re-lock window |

## Verification
The bench builds the block with HOLD_W = 6 and the default MIN_WIN = 16. The narrow width makes the full-scale interval of 63 cycles short enough to run end to end, next to the zero-as-one case and short intervals. The 16-cycle window lets the bench place lock both before and after the minimum boundary, including exactly at cycle 16 and at cycles 15 and 17. It also changes the interval during a window to check that the value is reloaded, and it drops the mode flag in both the gated and the re-lock phase.

// File: rtl/dllr_pkg.sv
package dllr_pkg;

  typedef enum logic [1:0] {
    ST_OPEN   = 2'd0,
    ST_GATED  = 2'd1,
    ST_RELOCK = 2'd2
  } dllr_state_t;

  // Effective countdown length: a programmed zero behaves as one cycle.
  function automatic logic [31:0] eff_hold(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

endpackage

// File: rtl/dllr_hold_timer.sv
module dllr_hold_timer #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [HOLD_W-1:0] load_val,
  output logic              expire
);
  import dllr_pkg::*;

  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= HOLD_W'(eff_hold(32'(load_val)));
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == HOLD_W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt != '0)); // R4

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt)); // R9

endmodule

// File: rtl/dllr_win_counter.sv
module dllr_win_counter #(
  parameter int MIN_WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic win_done
);
  localparam int WIN_W = (MIN_WIN > 2) ? $clog2(MIN_WIN) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(MIN_WIN - 1);

  logic [WIN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign win_done = (cnt == LAST);

  AST_WIN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && run && !clr) |=> win_done); // R7

  AST_WIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !win_done); // R6

endmodule

// File: rtl/dllr_relock_timer.sv
module dllr_relock_timer #(
  parameter int HOLD_W  = 16,
  parameter int MIN_WIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_gated,
  input  logic [HOLD_W-1:0] hold_interval,
  input  logic              dll_lock,
  output logic              dll_clk_en,
  output logic              relock_busy
);
  import dllr_pkg::*;

  dllr_state_t state, state_nxt;

  // Named internal events
  logic tmr_load, tmr_run, tmr_expire;
  logic win_clr, win_run, win_done;
  logic regate_evt, enter_evt, leave_evt;

  assign enter_evt  = deep_gated && (state == ST_OPEN);
  assign leave_evt  = !deep_gated && (state != ST_OPEN);
  assign regate_evt = deep_gated && (state == ST_RELOCK) && win_done && dll_lock;

  assign tmr_load = enter_evt || regate_evt;
  assign tmr_run  = deep_gated && (state == ST_GATED);
  assign win_clr  = (state != ST_RELOCK);
  assign win_run  = (state == ST_RELOCK);

  dllr_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .run      (tmr_run),
    .load_val (hold_interval),
    .expire   (tmr_expire)
  );

  dllr_win_counter #(.MIN_WIN(MIN_WIN)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (win_clr),
    .run      (win_run),
    .win_done (win_done)
  );

  always_comb begin
    state_nxt = state;
    if (!deep_gated) begin
      state_nxt = ST_OPEN;
    end else begin
      unique case (state)
        ST_OPEN:   state_nxt = ST_GATED;
        ST_GATED:  if (tmr_expire) state_nxt = ST_RELOCK;
        ST_RELOCK: if (regate_evt) state_nxt = ST_GATED;
        default:   state_nxt = ST_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OPEN;
    else        state <= state_nxt;
  end

  assign dll_clk_en  = (state != ST_GATED);
  assign relock_busy = (state == ST_RELOCK);

  AST_OPEN_WHEN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !deep_gated |=> (dll_clk_en && !relock_busy)); // R9

  AST_BUSY_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    relock_busy |-> dll_clk_en); // R5

  AST_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_gated && relock_busy && !win_done) |=> relock_busy); // R6

  AST_WAIT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_gated && relock_busy && !dll_lock) |=> relock_busy); // R7

  AST_REGATE: assert property (@(posedge clk) disable iff (!rst_n)
    regate_evt |=> !dll_clk_en); // R8

  AST_EXPIRE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> relock_busy); // R5

  AST_ENTRY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> !dll_clk_en); // R3

endmodule

// File: tb/dllr_relock_timer_test.sv
module dllr_relock_timer_test;
  localparam int HW = 6;
  localparam int MW = 16;
  localparam int NV = 6;

  // Vector table: entry hold, lock cycle in window, hold for the next interval
  localparam int VH [NV] = '{3, 0, 63, 1, 10, 2};
  localparam int VD [NV] = '{1, 16, 20, 17, 15, 40};
  localparam int V2 [NV] = '{5, 2, 1, 0, 63, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic deep_gated = 1'b0;
  logic [HW-1:0] hold_interval = '0;
  logic dll_lock = 1'b0;
  logic dll_clk_en, relock_busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dllr_relock_timer #(.HOLD_W(HW), .MIN_WIN(MW)) uut (
    .clk(clk), .rst_n(rst_n), .deep_gated(deep_gated),
    .hold_interval(hold_interval), .dll_lock(dll_lock),
    .dll_clk_en(dll_clk_en), .relock_busy(relock_busy)
  );

  function automatic int exp_hold(int h);
    return (h < 1) ? 1 : h;
  endfunction

  function automatic int exp_win(int d);
    return (d > MW) ? d : MW;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count negedges with the DLL clock gated; leaves at the first open negedge.
  task automatic count_gated(output int g);
    g = 0;
    while (dll_clk_en == 1'b0 && g < 200) begin
      g++;
      @(negedge clk);
    end
  endtask

  // Count window negedges, raising lock in window cycle d.
  task automatic count_window(input int d, input int next_hold, output int u);
    u = 0;
    while (relock_busy == 1'b1 && u < 200) begin
      u++;
      if (u == d) dll_lock = 1'b1;
      if (u == 1) hold_interval = HW'(next_hold);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int g, u;
    @(negedge clk);
    chk("R1 en in reset", int'(dll_clk_en), 1);
    chk("R1 busy in reset", int'(relock_busy), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 en after reset", int'(dll_clk_en), 1);
    chk("R1 busy after reset", int'(relock_busy), 0);

    // R2: outside the deepest mode, inputs have no effect
    for (int i = 0; i < 8; i++) begin
      hold_interval = HW'(i * 7);
      dll_lock = i[0];
      @(negedge clk);
      chk("R2 en idle", int'(dll_clk_en), 1);
      chk("R2 busy idle", int'(relock_busy), 0);
    end
    dll_lock = 1'b0;

    // Table walk: R3/R4 entry interval, R5 window, R6/R7 length, R8 reload
    for (int v = 0; v < NV; v++) begin
      hold_interval = HW'(VH[v]);
      deep_gated = 1'b1;
      @(negedge clk);
      count_gated(g);
      chk((VH[v] == 0) ? "R4 zero hold" : "R3 gated length", g, exp_hold(VH[v]));
      chk("R5 window busy", int'(relock_busy), 1);
      chk("R5 window en", int'(dll_clk_en), 1);
      count_window(VD[v], V2[v], u);
      dll_lock = 1'b0;
      chk((VD[v] > MW) ? "R7 late lock window" : "R6 min window", u, exp_win(VD[v]));
      count_gated(g);
      chk("R8 reloaded interval", g, exp_hold(V2[v]));
      chk("R8 second window", int'(relock_busy), 1);
      deep_gated = 1'b0;
      @(negedge clk);
      chk("R9 exit en", int'(dll_clk_en), 1);
      chk("R9 exit busy", int'(relock_busy), 0);
      @(negedge clk);
    end

    // R9: leave during gated phase, then re-entry restarts a full interval
    hold_interval = HW'(20);
    deep_gated = 1'b1;
    repeat (6) @(negedge clk);
    deep_gated = 1'b0;
    @(negedge clk);
    chk("R9 exit mid gate en", int'(dll_clk_en), 1);
    chk("R9 exit mid gate busy", int'(relock_busy), 0);
    repeat (3) @(negedge clk);
    deep_gated = 1'b1;
    @(negedge clk);
    count_gated(g);
    chk("R9 full restart", g, 20);

    // R9: leave during a re-lock window with lock held low
    repeat (4) @(negedge clk);
    chk("R7 still waiting", int'(relock_busy), 1);
    deep_gated = 1'b0;
    @(negedge clk);
    chk("R9 exit mid window en", int'(dll_clk_en), 1);
    chk("R9 exit mid window busy", int'(relock_busy), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule